// File: doc/BRIEF.md
# Dual-Port Load/Store Line Splitter

This block sits between one load/store requester and two 128-bit line ports of the memory side. The even port handles 16-byte lines whose address bit 4 is 0. The odd port handles lines where that bit is 1. A request has a 48-bit byte address, a binary byte count and load/store flags. A store also carries up to 64 bits of data. The block turns the request into at most two line sub-requests. Each sub-request has a line address, a per-byte enable and lane-aligned data. Bytes move in memory order, and no endianness swap is applied.

When a request crosses a 16-byte boundary, it lands on both ports at the same time: one line goes to the even port and the next line goes to the odd port. Which port gets a line depends only on that line's address bit 4, never on which part of the request it holds. On a load, the block waits for every port it activated, then shifts the returned bytes back into requester order.

The controller has three states. SP_IDLE accepts a request (the *accept* transition to SP_WAIT). SP_WAIT holds each activated port valid until that port reports done. The *all-done* transition goes to SP_DONE, and that transition is taken at once if no port is activated. SP_DONE lasts one cycle, presents the load result, and then takes the *retire* transition back to SP_IDLE.

Top module: `ldst_split`

## Requirements
- R1: A byte at address A goes to port A[4] (0 = even port, 1 = odd port). It appears there with `port_line` = A[47:4] and enable bit `port_be[A[4]][A[3:0]]` set.
- R2: The enabled bytes are exactly addresses `req_addr` to `req_addr + n - 1`. Here n is `req_len` for values 0 to 16, and n is 16 for any larger value.
- R3: A request that crosses a line boundary uses line `req_addr[47:4]` and line `req_addr[47:4] + 1`. That sum wraps modulo 2^44 at the top of the address space.
- R4: A port that has no enabled byte for the current request never raises `port_valid`.
- R5: On a store, byte k of `req_wdata` (k < 8 and k < n) appears on byte lane (A[3:0]) of port A[4]'s `port_wdata`, where A = `req_addr + k`.
- R6: `port_ld` and `port_st` repeat the request's load and store flags on every port while that port is valid.
- R7: A port stays valid, with its line and enables unchanged, until it sees `port_done`. Its valid drops in the cycle after the done.
- R8: On a load, `ld_valid` pulses for one cycle after every activated port has reported done. Byte k of `ld_rdata` (k < min(n, 8)) is then the byte returned for address `req_addr + k`. A store produces no `ld_valid`.
- R9: `req_busy` rises in the cycle after a request is accepted and stays high through the `ld_valid` cycle. A request presented while busy is ignored.
- R10: After reset the block is idle: `req_busy`, `ld_valid` and both `port_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_ld | input | 1 | Load request |
| req_st | input | 1 | Store request |
| req_addr | input | 48 | Byte address of the request |
| req_len | input | 5 | Byte count, binary (1 to 16 intended) |
| req_wdata | input | 64 | Store data, memory byte order |
| req_busy | output | 1 | Request in flight; new requests ignored |
| ld_valid | output | 1 | One-cycle load result strobe |
| ld_rdata | output | 64 | Gathered load data |
| port_valid | output | 2 | Sub-request valid, index 0 even, 1 odd |
| port_ld | output | 2 | Load flag per port |
| port_st | output | 2 | Store flag per port |
| port_line | output | 2x44 | Line address per port |
| port_be | output | 2x16 | Byte enables per port |
| port_wdata | output | 2x128 | Lane-aligned store data per port |
| port_done | input | 2 | Port has completed its sub-request |
| port_rdata | input | 2x128 | Line data returned with done |

## Verification
The bench targets four kinds of request:
- Requests that cross a line boundary from an even line and from an odd line. A design that routed by request half rather than by address bit 4 would swap the line addresses between the ports.
- A request that wraps from the last line of the address space to line 0. This catches a carry that is dropped or widened.
- A zero-length request and a request longer than 16 bytes. These show whether an empty port is raised, or whether the enable mask overflows.
- Ports that answer with unequal delays, and a request held high during busy. A block that finished on the first done, or re-accepted while busy, would return a mixed load result or start a second transaction.

// File: rtl/ldst_split_pkg.sv
package ldst_split_pkg;
    typedef enum logic [1:0] {
        SP_IDLE,
        SP_WAIT,
        SP_DONE
    } sp_state_e;
endpackage

// File: rtl/ldst_lane_split.sv
module ldst_lane_split #(
    parameter int ADDR_W     = 48,
    parameter int DATA_W     = 64,
    parameter int LINE_BYTES = 16,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int LINE_W    = ADDR_W - OFF_W,
    localparam int LANE_W    = LINE_BYTES * 8,
    localparam int LEN_W     = OFF_W + 1
) (
    input  logic [ADDR_W-1:0]                 addr_i,
    input  logic [LEN_W-1:0]                  len_i,
    input  logic [DATA_W-1:0]                 wdata_i,
    output logic [1:0][LINE_W-1:0]            line_o,
    output logic [1:0][LINE_BYTES-1:0]        be_o,
    output logic [1:0][LANE_W-1:0]            wdata_o
);
    logic [OFF_W-1:0]          off;
    logic [LINE_W-1:0]         near_line;
    logic [LINE_W-1:0]         far_line;
    logic [LINE_BYTES-1:0]     base_mask;
    logic [2*LINE_BYTES-1:0]   span_mask;
    logic [2*LANE_W-1:0]       span_data;

    assign off       = addr_i[OFF_W-1:0];
    assign near_line = addr_i[ADDR_W-1:OFF_W];
    assign far_line  = near_line + 1'b1;

    // Contiguous run of n ones, n clamped to one full line
    always_comb begin
        for (int i = 0; i < LINE_BYTES; i++) begin
            base_mask[i] = (int'(len_i) > i);
        end
    end

    assign span_mask = {{LINE_BYTES{1'b0}}, base_mask} << off;
    assign span_data = {{(2*LANE_W-DATA_W){1'b0}}, wdata_i} << {off, 3'b000};

    // The port whose parity matches the near line gets the low half
    for (genvar p = 0; p < 2; p++) begin : g_port
        logic takes_near;
        assign takes_near = (near_line[0] == 1'(p));
        assign line_o[p]  = takes_near ? near_line : far_line;
        assign be_o[p]    = takes_near ? span_mask[LINE_BYTES-1:0]
                                       : span_mask[2*LINE_BYTES-1:LINE_BYTES];
        assign wdata_o[p] = takes_near ? span_data[LANE_W-1:0]
                                       : span_data[2*LANE_W-1:LANE_W];
    end
endmodule

// File: rtl/ldst_load_gather.sv
module ldst_load_gather #(
    parameter int DATA_W     = 64,
    parameter int LINE_BYTES = 16,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int LANE_W    = LINE_BYTES * 8,
    localparam int DATA_B    = DATA_W / 8
) (
    input  logic [OFF_W-1:0]  off_i,
    input  logic [LANE_W-1:0] near_i,
    input  logic [LANE_W-1:0] far_i,
    output logic [DATA_W-1:0] data_o
);
    logic [2*LANE_W-1:0] span;
    assign span = {far_i, near_i};

    always_comb begin
        data_o = '0;
        for (int k = 0; k < DATA_B; k++) begin
            if (int'(off_i) + k < 2*LINE_BYTES) begin
                data_o[k*8 +: 8] = span[(int'(off_i) + k)*8 +: 8];
            end
        end
    end
endmodule

// File: rtl/ldst_split.sv
module ldst_split
    import ldst_split_pkg::*;
#(
    parameter int ADDR_W     = 48,
    parameter int DATA_W     = 64,
    parameter int LINE_BYTES = 16,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int LINE_W    = ADDR_W - OFF_W,
    localparam int LANE_W    = LINE_BYTES * 8,
    localparam int LEN_W     = OFF_W + 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_ld,
    input  logic                          req_st,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [LEN_W-1:0]              req_len,
    input  logic [DATA_W-1:0]             req_wdata,
    output logic                          req_busy,
    output logic                          ld_valid,
    output logic [DATA_W-1:0]             ld_rdata,
    output logic [1:0]                    port_valid,
    output logic [1:0]                    port_ld,
    output logic [1:0]                    port_st,
    output logic [1:0][LINE_W-1:0]        port_line,
    output logic [1:0][LINE_BYTES-1:0]    port_be,
    output logic [1:0][LANE_W-1:0]        port_wdata,
    input  logic [1:0]                    port_done,
    input  logic [1:0][LANE_W-1:0]        port_rdata
);
    sp_state_e              state_q, state_d;
    logic [ADDR_W-1:0]      addr_q;
    logic [LEN_W-1:0]       len_q;
    logic [DATA_W-1:0]      wdata_q;
    logic                   op_ld_q, op_st_q;
    logic [1:0]             got_q;
    logic [1:0][LANE_W-1:0] rbuf_q;
    logic [1:0]             active;
    logic                   accept;
    logic                   all_done;
    logic                   near_sel;
    logic [DATA_W-1:0]      gathered;

    ldst_lane_split #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_BYTES(LINE_BYTES)
    ) u_split (
        .addr_i  (addr_q),
        .len_i   (len_q),
        .wdata_i (wdata_q),
        .line_o  (port_line),
        .be_o    (port_be),
        .wdata_o (port_wdata)
    );

    assign near_sel = addr_q[OFF_W];

    ldst_load_gather #(
        .DATA_W(DATA_W), .LINE_BYTES(LINE_BYTES)
    ) u_gather (
        .off_i  (addr_q[OFF_W-1:0]),
        .near_i (rbuf_q[near_sel]),
        .far_i  (rbuf_q[~near_sel]),
        .data_o (gathered)
    );

    assign active   = {|port_be[1], |port_be[0]};
    assign accept   = (state_q == SP_IDLE) && (req_ld || req_st);
    assign all_done = &(~active | got_q | (port_done & port_valid));

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SP_IDLE: if (accept)   state_d = SP_WAIT;
            SP_WAIT: if (all_done) state_d = SP_DONE;
            SP_DONE:               state_d = SP_IDLE;
            default:               state_d = SP_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SP_IDLE;
        else        state_q <= state_d;
    end

    // Request capture and per-port completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            len_q   <= '0;
            wdata_q <= '0;
            op_ld_q <= 1'b0;
            op_st_q <= 1'b0;
            got_q   <= '0;
            rbuf_q  <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            len_q   <= req_len;
            wdata_q <= req_wdata;
            op_ld_q <= req_ld;
            op_st_q <= req_st;
            got_q   <= '0;
            rbuf_q  <= '0;
        end else if (state_q == SP_WAIT) begin
            for (int p = 0; p < 2; p++) begin
                if (port_valid[p] && port_done[p]) begin
                    got_q[p]  <= 1'b1;
                    rbuf_q[p] <= port_rdata[p];
                end
            end
        end
    end

    // Outputs
    always_comb begin
        req_busy   = 1'b0;
        ld_valid   = 1'b0;
        port_valid = '0;
        unique case (state_q)
            SP_IDLE: ;
            SP_WAIT: begin
                req_busy   = 1'b1;
                port_valid = active & ~got_q;
            end
            SP_DONE: begin
                req_busy = 1'b1;
                ld_valid = op_ld_q;
            end
            default: ;
        endcase
        port_ld  = port_valid & {2{op_ld_q}};
        port_st  = port_valid & {2{op_st_q}};
        ld_rdata = ld_valid ? gathered : '0;
    end

    for (genvar p = 0; p < 2; p++) begin : g_chk
        // R7
        hold_until_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
            port_valid[p] && !port_done[p] |=>
                port_valid[p] && $stable(port_line[p]) && $stable(port_be[p]));
        // R7
        drop_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
            port_valid[p] && port_done[p] |=> !port_valid[p]);
        // R4
        no_empty_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
            port_valid[p] |-> (port_be[p] != '0));
        // R9
        valid_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
            port_valid[p] |-> req_busy);
    end

    // R8
    ld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> !ld_valid);
    // R9
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ld || req_st) && !req_busy |=> req_busy);
    // R8
    ld_inside_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> req_busy && !port_valid[0] && !port_valid[1]);
endmodule

// File: tb/ldst_split_tb.sv
`timescale 1ns/1ps
module ldst_split_tb;
    logic                clk = 1'b0;
    logic                rst_n;
    logic                req_ld, req_st;
    logic [47:0]         req_addr;
    logic [4:0]          req_len;
    logic [63:0]         req_wdata;
    logic                req_busy, ld_valid;
    logic [63:0]         ld_rdata;
    logic [1:0]          port_valid, port_ld, port_st;
    logic [1:0][43:0]    port_line;
    logic [1:0][15:0]    port_be;
    logic [1:0][127:0]   port_wdata;
    logic [1:0]          port_done;
    logic [1:0][127:0]   port_rdata;

    int total = 0;
    int fails = 0;

    always #10 clk = ~clk;

    ldst_split u_dut (
        .clk(clk), .rst_n(rst_n), .req_ld(req_ld), .req_st(req_st),
        .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
        .req_busy(req_busy), .ld_valid(ld_valid), .ld_rdata(ld_rdata),
        .port_valid(port_valid), .port_ld(port_ld), .port_st(port_st),
        .port_line(port_line), .port_be(port_be), .port_wdata(port_wdata),
        .port_done(port_done), .port_rdata(port_rdata)
    );

    typedef struct packed {
        logic [47:0] addr;
        logic [4:0]  len;
        logic        st;
        logic [63:0] wd;
        logic [3:0]  d0;
        logic [3:0]  d1;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{48'h0000_0000_1000, 5'd8,  1'b0, 64'h0,                   4'd0, 4'd0},
        '{48'h0000_0000_1010, 5'd4,  1'b1, 64'h1122_3344_5566_7788, 4'd1, 4'd2},
        '{48'h0000_0000_100C, 5'd8,  1'b0, 64'h0,                   4'd2, 4'd0},
        '{48'h0000_0000_201A, 5'd16, 1'b1, 64'hA1B2_C3D4_E5F6_0718, 4'd0, 4'd3},
        '{48'h0000_0000_3030, 5'd16, 1'b0, 64'h0,                   4'd0, 4'd1},
        '{48'h0000_0000_040F, 5'd1,  1'b0, 64'h0,                   4'd3, 4'd0},
        '{48'h0000_0000_051F, 5'd3,  1'b1, 64'h0000_0000_00CA_FEBE, 4'd5, 4'd0},
        '{48'hFFFF_FFFF_FFFC, 5'd8,  1'b0, 64'h0,                   4'd1, 4'd4}
    };

    logic [1:0]         seen;
    logic [1:0][43:0]   rec_line;
    logic [1:0][15:0]   rec_be;
    logic [1:0][127:0]  rec_wd;
    logic [1:0]         rec_ld, rec_st;
    logic               got_ld;
    logic [63:0]        got_data;

    function automatic logic [7:0] mem_byte(input logic [47:0] a);
        return a[7:0] ^ a[15:8] ^ a[47:40] ^ 8'h3C;
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic txn(input logic [47:0] addr, input logic [4:0] len,
                       input logic st, input logic [63:0] wd,
                       input int d0, input int d1, input bit poke);
        int cnt [2];
        int dly [2];
        int n;
        logic [1:0]        exp_use;
        logic [1:0][43:0]  exp_line;
        logic [1:0][15:0]  exp_be;
        dly[0] = d0; dly[1] = d1; cnt[0] = 0; cnt[1] = 0;
        seen = '0; got_ld = 1'b0; got_data = '0;
        @(negedge clk);
        req_ld = !st; req_st = st; req_addr = addr; req_len = len; req_wdata = wd;
        @(negedge clk);
        if (poke) begin
            req_ld = 1'b1; req_st = 1'b0; req_addr = addr ^ 48'h100; req_len = 5'd4;
        end else begin
            req_ld = 1'b0; req_st = 1'b0;
        end
        check(req_busy === 1'b1, "R9 busy after accept", 128'(req_busy), 128'd1);
        for (int guard = 0; guard < 200; guard++) begin
            if (guard != 0) @(negedge clk);
            port_done = '0;
            if (ld_valid) begin got_ld = 1'b1; got_data = ld_rdata; end
            if (!req_busy) break;
            for (int p = 0; p < 2; p++) begin
                if (port_valid[p]) begin
                    if (!seen[p]) begin
                        seen[p] = 1'b1;
                        rec_line[p] = port_line[p];
                        rec_be[p] = port_be[p];
                        rec_wd[p] = port_wdata[p];
                        rec_ld[p] = port_ld[p];
                        rec_st[p] = port_st[p];
                    end
                    if (cnt[p] >= dly[p]) begin
                        port_done[p] = 1'b1;
                        for (int l = 0; l < 16; l++)
                            port_rdata[p][l*8 +: 8] = mem_byte({port_line[p], 4'(l)});
                    end else begin
                        cnt[p]++;
                    end
                end
            end
        end
        req_ld = 1'b0; req_st = 1'b0;
        n = (len > 16) ? 16 : int'(len);
        exp_use = '0; exp_line = '0; exp_be = '0;
        for (int k = 0; k < n; k++) begin
            logic [47:0] a;
            a = addr + 48'(k);
            exp_use[a[4]] = 1'b1;
            exp_line[a[4]] = a[47:4];
            exp_be[a[4]][a[3:0]] = 1'b1;
        end
        for (int p = 0; p < 2; p++) begin
            check(seen[p] == exp_use[p], "R4 port activation", 128'(seen[p]), 128'(exp_use[p]));
            if (seen[p] && exp_use[p]) begin
                check(rec_line[p] == exp_line[p], "R1/R3 line address", 128'(rec_line[p]), 128'(exp_line[p]));
                check(rec_be[p] == exp_be[p], "R2 byte enables", 128'(rec_be[p]), 128'(exp_be[p]));
                check(rec_ld[p] == !st && rec_st[p] == st, "R6 flags",
                      128'({rec_ld[p], rec_st[p]}), 128'({!st, st}));
            end
        end
        if (st) begin
            for (int k = 0; k < n && k < 8; k++) begin
                logic [47:0] a;
                a = addr + 48'(k);
                check(rec_wd[a[4]][a[3:0]*8 +: 8] == wd[k*8 +: 8], "R5 store lane",
                      128'(rec_wd[a[4]][a[3:0]*8 +: 8]), 128'(wd[k*8 +: 8]));
            end
            check(!got_ld, "R8 no ld_valid on store", 128'(got_ld), 128'd0);
        end else begin
            check(got_ld, "R8 ld_valid seen", 128'(got_ld), 128'd1);
            for (int k = 0; k < n && k < 8; k++) begin
                logic [47:0] a;
                a = addr + 48'(k);
                check(got_data[k*8 +: 8] == mem_byte(a), "R8 load byte",
                      128'(got_data[k*8 +: 8]), 128'(mem_byte(a)));
            end
        end
        @(negedge clk);
        check(!req_busy && port_valid == 2'b00, "R9 idle after completion",
              128'({req_busy, port_valid}), 128'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_ld = 1'b0; req_st = 1'b0; req_addr = '0;
        req_len = '0; req_wdata = '0; port_done = '0; port_rdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10
        check(!req_busy && !ld_valid && port_valid == 2'b00, "R10 reset state",
              128'({req_busy, ld_valid, port_valid}), 128'd0);

        for (int v = 0; v < NV; v++) begin
            txn(VECS[v].addr, VECS[v].len, VECS[v].st, VECS[v].wd,
                int'(VECS[v].d0), int'(VECS[v].d1), 1'b0);
        end

        // R2: zero length enables nothing, no port raised
        txn(48'h0000_0000_0700, 5'd0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 1'b0);
        // R2: length above 16 clamps to one line worth of bytes
        txn(48'h0000_0000_0608, 5'd20, 1'b0, 64'h0, 1, 2, 1'b0);
        // R9: request held during busy is ignored
        txn(48'h0000_0000_08FA, 5'd10, 1'b1, 64'h0102_0304_0506_0708, 6, 3, 1'b1);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule